// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor

This block is a minimal processor with exactly one instruction. The instruction subtracts one memory word from another, stores the difference over the first, and jumps when that difference is negative. There is no register file and no opcode field. Every operand, every instruction word and every result lives in one word-addressed memory held inside the block. Each instruction is three consecutive words: the destination address, then the source address, then the branch target. Programs build moves, additions and loops out of this one operation, for example by clearing a word with the same address as destination and source.

Memory is preloaded through a debug port while reset is held. When reset is released the processor starts at a given start address. A multi-cycle controller runs seven states per instruction. S_FETCH_DST, S_FETCH_SRC and S_FETCH_TGT read the three instruction words. S_LOAD_DST and S_LOAD_SRC read the two operands. S_WRITE stores the difference and records its sign. S_UPDATE picks the next program counter.

From S_UPDATE there are two transitions. The controller goes to S_HALT when the branch is taken and the target is the instruction's own address. Otherwise it returns to S_FETCH_DST. S_HALT is left only by reset. The debug port reads memory at any time but writes it only during reset or halt.

Top module: `subneg_core`

## Requirements
- R1: While reset is asserted, `pc` equals `start_addr` and `halt` is low. After release, the first instruction is fetched from `start_addr`.
- R2: Each instruction takes exactly seven clock cycles. When the stored result has bit 31 clear, `pc` advances by 3 at the end of the seventh cycle.
- R3: The word at the destination address is replaced by destination minus source, computed modulo 2^32.
- R4: A result is negative exactly when its bit 31 is set. A negative result loads `pc` with the target field. Instructions skipped over by the jump are not executed.
- R5: An instruction whose destination and source addresses are equal leaves zero at that address. Zero is not negative, so execution falls through.
- R6: A target equal to the address of the next instruction gives the same `pc` sequence whether or not the result is negative.
- R7: A taken branch whose target equals the instruction's own address enters the halted state. There `halt` is high, `pc` holds that address and memory is no longer written by the core. Only reset leaves this state.
- R8: Memory holds 256 words. Only the low 8 bits of each address field are used, and `pc` arithmetic wraps modulo 256.
- R9: `dbg_rdata` always shows the word at `dbg_addr`. A write from `dbg_we` takes effect only while reset is asserted or the core is halted, and is ignored while a program runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 8 | Address of the first instruction after reset |
| dbg_we | input | 1 | Debug memory write enable |
| dbg_addr | input | 8 | Debug memory address for read and write |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Memory word at `dbg_addr` |
| pc | output | 8 | Current program counter |
| halt | output | 1 | High once the core has halted |

## Verification
The main program mixes several kinds of instruction. A self-clearing instruction is followed by a negative result whose target equals the next instruction, which separates a correct fall-through from a taken branch. An add built from two subtractions checks the arithmetic. A subtraction that passes through the most negative value shows that the sign bit alone decides the branch, not a true signed comparison. A taken jump over a trap instruction proves that skipped code has no effect. The halting instruction uses an address field with set upper bits, and a second program starts near the top of memory so that `pc` wraps through zero. A debug write issued mid-run and another issued after halt tell an ignored write apart from an accepted one.

// File: rtl/subneg_pkg.sv
package subneg_pkg;

    localparam int INSN_WORDS = 3;

    typedef enum logic [2:0] {
        S_FETCH_DST,
        S_FETCH_SRC,
        S_FETCH_TGT,
        S_LOAD_DST,
        S_LOAD_SRC,
        S_WRITE,
        S_UPDATE,
        S_HALT
    } sn_state_e;

    typedef enum logic [2:0] {
        AS_PC0,
        AS_PC1,
        AS_PC2,
        AS_DST,
        AS_SRC
    } sn_asel_e;

endpackage

// File: rtl/subneg_mem.sv
module subneg_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] core_raddr,
    output logic [DATA_W-1:0] core_rdata,
    input  logic [ADDR_W-1:0] dbg_raddr,
    output logic [DATA_W-1:0] dbg_rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign core_rdata = words[core_raddr];
    assign dbg_rdata  = words[dbg_raddr];

endmodule

// File: rtl/subneg_alu.sv
module subneg_alu #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    output logic [DATA_W-1:0] diff,
    output logic              is_neg
);

    always_comb begin
        diff   = minuend - subtrahend;
        is_neg = diff[DATA_W-1];
    end

endmodule

// File: rtl/subneg_ctrl.sv
module subneg_ctrl
    import subneg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      neg_flag,
    input  logic      tgt_is_pc,
    output sn_state_e state,
    output sn_asel_e  asel,
    output logic      ld_dst,
    output logic      ld_src,
    output logic      ld_tgt,
    output logic      ld_opd,
    output logic      ld_ops,
    output logic      core_we,
    output logic      pc_upd,
    output logic      halted
);

    sn_state_e state_q;
    sn_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH_DST: state_d = S_FETCH_SRC;
            S_FETCH_SRC: state_d = S_FETCH_TGT;
            S_FETCH_TGT: state_d = S_LOAD_DST;
            S_LOAD_DST:  state_d = S_LOAD_SRC;
            S_LOAD_SRC:  state_d = S_WRITE;
            S_WRITE:     state_d = S_UPDATE;
            S_UPDATE:    state_d = (neg_flag && tgt_is_pc) ? S_HALT : S_FETCH_DST;
            S_HALT:      state_d = S_HALT;
            default:     state_d = S_FETCH_DST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_FETCH_DST;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        asel    = AS_PC0;
        ld_dst  = 1'b0;
        ld_src  = 1'b0;
        ld_tgt  = 1'b0;
        ld_opd  = 1'b0;
        ld_ops  = 1'b0;
        core_we = 1'b0;
        pc_upd  = 1'b0;
        halted  = 1'b0;
        unique case (state_q)
            S_FETCH_DST: begin
                asel   = AS_PC0;
                ld_dst = 1'b1;
            end
            S_FETCH_SRC: begin
                asel   = AS_PC1;
                ld_src = 1'b1;
            end
            S_FETCH_TGT: begin
                asel   = AS_PC2;
                ld_tgt = 1'b1;
            end
            S_LOAD_DST: begin
                asel   = AS_DST;
                ld_opd = 1'b1;
            end
            S_LOAD_SRC: begin
                asel   = AS_SRC;
                ld_ops = 1'b1;
            end
            S_WRITE: begin
                asel    = AS_DST;
                core_we = 1'b1;
            end
            S_UPDATE: begin
                pc_upd = 1'b1;
            end
            S_HALT: begin
                halted = 1'b1;
            end
            default: begin
                asel = AS_PC0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/subneg_core.sv
module subneg_core
    import subneg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic              halt
);

    sn_state_e state;
    sn_asel_e  asel;
    logic ld_dst, ld_src, ld_tgt, ld_opd, ld_ops, core_we, pc_upd, halted;

    logic [ADDR_W-1:0] pc_q, dst_q, src_q, tgt_q;
    logic [DATA_W-1:0] opd_q, ops_q;
    logic              neg_q;

    logic [ADDR_W-1:0] core_raddr;
    logic [DATA_W-1:0] core_rdata;
    logic [DATA_W-1:0] diff;
    logic              diff_neg;

    logic              dbg_ok;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;

    subneg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .neg_flag (neg_q),
        .tgt_is_pc(tgt_q == pc_q),
        .state    (state),
        .asel     (asel),
        .ld_dst   (ld_dst),
        .ld_src   (ld_src),
        .ld_tgt   (ld_tgt),
        .ld_opd   (ld_opd),
        .ld_ops   (ld_ops),
        .core_we  (core_we),
        .pc_upd   (pc_upd),
        .halted   (halted)
    );

    always_comb begin
        unique case (asel)
            AS_PC0:  core_raddr = pc_q;
            AS_PC1:  core_raddr = pc_q + ADDR_W'(1);
            AS_PC2:  core_raddr = pc_q + ADDR_W'(2);
            AS_DST:  core_raddr = dst_q;
            AS_SRC:  core_raddr = src_q;
            default: core_raddr = pc_q;
        endcase
    end

    assign dbg_ok    = dbg_we && (!rst_n || halted);
    assign mem_we    = core_we || dbg_ok;
    assign mem_waddr = core_we ? dst_q : dbg_addr;
    assign mem_wdata = core_we ? diff  : dbg_wdata;

    subneg_mem #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_mem (
        .clk       (clk),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .core_raddr(core_raddr),
        .core_rdata(core_rdata),
        .dbg_raddr (dbg_addr),
        .dbg_rdata (dbg_rdata)
    );

    subneg_alu #(
        .DATA_W(DATA_W)
    ) u_alu (
        .minuend   (opd_q),
        .subtrahend(ops_q),
        .diff      (diff),
        .is_neg    (diff_neg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= start_addr;
            dst_q <= '0;
            src_q <= '0;
            tgt_q <= '0;
            opd_q <= '0;
            ops_q <= '0;
            neg_q <= 1'b0;
        end else begin
            if (ld_dst)  dst_q <= core_rdata[ADDR_W-1:0];
            if (ld_src)  src_q <= core_rdata[ADDR_W-1:0];
            if (ld_tgt)  tgt_q <= core_rdata[ADDR_W-1:0];
            if (ld_opd)  opd_q <= core_rdata;
            if (ld_ops)  ops_q <= core_rdata;
            if (core_we) neg_q <= diff_neg;
            if (pc_upd)  pc_q  <= neg_q ? tgt_q : pc_q + ADDR_W'(INSN_WORDS);
        end
    end

    assign pc   = pc_q;
    assign halt = halted;

endmodule

// File: rtl/subneg_core_chk.sv
module subneg_core_chk
    import subneg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input sn_state_e         state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] tgt,
    input logic              neg,
    input logic              halt
);

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(pc));

    assert_halt_on_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> ($past(neg) && ($past(tgt) == $past(pc))));

    assert_pc_moves_after_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> ($past(state) == S_UPDATE));

    assert_write_then_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) |=> (state == S_UPDATE));

    assert_fallthrough_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UPDATE && !neg) |=> (pc == $past(pc) + ADDR_W'(3)));

    assert_branch_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UPDATE && neg) |=> (pc == $past(tgt)));

endmodule

bind subneg_core subneg_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .state(state),
    .pc   (pc_q),
    .tgt  (tgt_q),
    .neg  (neg_q),
    .halt (halt)
);

// File: tb/sim_subneg_core.sv
`timescale 1ns/1ps
module sim_subneg_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  start_addr = 8'd0;
    logic        dbg_we = 1'b0;
    logic [7:0]  dbg_addr = 8'd0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [7:0]  pc;
    logic        halt;

    subneg_core u0 (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .pc(pc), .halt(halt)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // behavioural reference: instruction-level model advanced every 7 clocks
    logic [31:0] m_mem [256];
    int          m_pc = 0;
    bit          m_halt = 1'b0;
    int          m_cnt = 0;

    function automatic void check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_pc   = int'(start_addr);
            m_halt = 1'b0;
        end else if (!m_halt) begin
            m_cnt++;
            if (m_cnt == 7) begin
                int d, s, t;
                logic [31:0] r;
                m_cnt = 0;
                d = int'(m_mem[m_pc][7:0]);
                s = int'(m_mem[(m_pc + 1) % 256][7:0]);
                t = int'(m_mem[(m_pc + 2) % 256][7:0]);
                r = m_mem[d] - m_mem[s];
                m_mem[d] = r;
                if (r[31]) begin
                    if (t == m_pc) m_halt = 1'b1;
                    else           m_pc = t;
                end else begin
                    m_pc = (m_pc + 3) % 256;
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model (R2, R4, R7)
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R2/R4 pc per cycle", {24'd0, pc}, m_pc);
            check("R7 halt per cycle", {31'd0, halt}, {31'd0, m_halt});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic poke(int a, logic [31:0] d);
        @(negedge clk);
        dbg_we    = 1'b1;
        dbg_addr  = 8'(a);
        dbg_wdata = d;
        if (!rst_n || m_halt) m_mem[a % 256] = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(int a, output logic [31:0] d);
        @(negedge clk);
        dbg_addr = 8'(a);
        #1 d = dbg_rdata;
    endtask

    task automatic insn(int at, logic [31:0] d, logic [31:0] s, logic [31:0] t);
        poke(at % 256, d);
        poke((at + 1) % 256, s);
        poke((at + 2) % 256, t);
    endtask

    task automatic wait_halt();
        while (!halt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    logic [31:0] rd;

    initial begin
        // ---------------- program 1 ----------------
        rst_n = 1'b0;
        start_addr = 8'd0;
        poke(101, 32'd7);
        poke(102, 32'd5);
        poke(103, 32'd123);
        poke(104, 32'd0);
        poke(105, 32'd0);
        poke(106, 32'd1);
        poke(107, 32'd3);
        poke(108, 32'd10);
        poke(109, 32'h8000_0000);
        poke(110, 32'd1);
        insn(0,  103, 103, 3);
        insn(3,  103, 101, 6);
        insn(6,  102, 103, 9);
        insn(9,  109, 110, 50);
        insn(12, 107, 108, 18);
        insn(15, 102, 102, 15);
        insn(18, 32'hFFFF_FF69, 106, 18);
        @(negedge clk);
        check("R1 reset pc", {24'd0, pc}, 32'd0);
        check("R1 reset halt", {31'd0, halt}, 32'd0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (10) @(negedge clk);
        poke(104, 32'd55);          // ignored while running
        wait_halt();
        check("R7 halted", {31'd0, halt}, 32'd1);
        check("R7 pc at halt", {24'd0, pc}, 32'd18);
        peek(103, rd); check("R6 negative fall-through result", rd, 32'hFFFF_FFF9);
        peek(102, rd); check("R3 add via two subtracts", rd, 32'd12);
        peek(109, rd); check("R4 sign bit rule", rd, 32'h7FFF_FFFF);
        peek(107, rd); check("R4 branch result", rd, 32'hFFFF_FFF9);
        peek(105, rd); check("R8 wrapped destination field", rd, 32'hFFFF_FFFF);
        peek(104, rd); check("R9 write ignored while running", rd, 32'd0);
        check("R9 model agrees on 104", rd, m_mem[104]);
        poke(104, 32'd77);          // accepted while halted
        peek(104, rd); check("R9 write accepted while halted", rd, 32'd77);
        check("R7 still halted after debug write", {31'd0, halt}, 32'd1);

        // ---------------- program 2 ----------------
        cmp_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        start_addr = 8'd250;
        poke(200, 32'd42);
        poke(201, 32'd5);
        poke(202, 32'd2);
        poke(203, 32'd0);
        poke(204, 32'd1);
        insn(250, 200, 200, 253);
        insn(253, 201, 202, 0);
        insn(0,   203, 204, 0);
        @(negedge clk);
        check("R1 reset pc second start", {24'd0, pc}, 32'd250);
        check("R1 reset halt second start", {31'd0, halt}, 32'd0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        wait_halt();
        peek(200, rd); check("R5 self subtract clears", rd, 32'd0);
        peek(201, rd); check("R3 plain subtract", rd, 32'd3);
        check("R8 pc wrapped to zero and halted", {24'd0, pc}, 32'd0);
        check("R7 halted second program", {31'd0, halt}, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule